// File: doc/BRIEF.md
# Programmable skew clock output generator

This block produces the clock outputs of one bank: four output pairs, each pair two identical pins. It runs from a fast tick clock whose period is one time unit (tU). The reference period is a whole number of ticks: 32, 16 or 8, chosen by a three-level range input. A free-running phase counter spans four reference periods, so divide-by-2 and divide-by-4 waveforms can be formed. Each pair takes a two-digit three-level code. The code selects a phase offset in tU steps, or a special mode on pairs 3 and 4.

Around the waveform generation, the block applies the bank controls. These are the edge polarity, a synchronous stop that exempts pair 2 so that pair 2 can keep feeding back, a test mode that disables single pairs, a straight pass of the reference in bypass, and power-down. Stopping and restarting never cut a pulse short.

Top module: `skew_clk_bank`

## Requirements
- R1: Each three-level input uses two bits, with LOW=00, MID=01 and HIGH=10; 11 reads as MID. While reset is asserted all outputs are LOW. After reset the latched settings are range MID, polarity rising and all codes MID. The value registered at the n-th rising clock edge after reset release (n from 0) shows reference phase n. Each pair drives its two pins identically.
- R2: A range of LOW, MID or HIGH gives a reference period of 32, 16 or 8 ticks. A new range is adopted only when the phase counter wraps, which happens after four reference periods.
- R3: On pairs 1 and 2, the code (high digit, low digit) taken as the index 3*high+low (0..8) selects a skew of index-4 tU. A positive skew delays the output. A zero-skew output is HIGH for the first half of each reference period.
- R4: On pairs 3 and 4, indexes 1..7 select a skew of 2*(index-4) tU. Index 0 (LL) selects divide-by-2: the output is HIGH for one reference period and LOW for the next.
- R5: Index 8 (HH) selects divide-by-4 on pair 3, HIGH for two reference periods out of four. On pair 4 it selects the zero-skew waveform inverted.
- R6: When polarity is LOW, every waveform is delayed by half a reference period. Polarity and codes are latched only at the start of a reference period.
- R7: A code change applied mid-period leaves the outputs unchanged until the next reference period starts.
- R8: In normal test mode (LOW), a HIGH stop input stops pairs 1, 3 and 4 but never pair 2. A pair freezes only in a tick where its running waveform is already at the stop level. After the stop is released, it resumes only where the running waveform leaves that level.
- R9: The stop level is LOW, except for pair 4 in inverted mode, whose stop level equals the latched polarity.
- R10: In test MID with the stop input HIGH, only the pairs whose latched code is LL are stopped, with the glitch-free rule of R8. All other pairs keep their programmed waveform.
- R11: In test HIGH, or test MID with the stop input LOW, every output equals the reference input sampled one clock earlier.
- R12: With power enable LOW, every output is LOW from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one period per time unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, passed through in bypass |
| range_sel | input | 2 | Three-level range select |
| test_sel | input | 2 | Three-level test mode |
| pol_rise | input | 1 | 1: align to reference rising edge, 0: falling edge |
| soe_stop | input | 1 | Synchronous stop request for the bank |
| pwr_on | input | 1 | 0 powers the bank down |
| pair_code | input | 16 | Four pair codes, pair k (0..3) at [4k+3:4k], high digit in the upper two bits |
| clk_out | output | 8 | Pair k drives bits 2k and 2k+1 |

## Verification
An error in the phase counter moves every edge of every pair in the first tick after it occurs. The reference model catches it at once. A wrongly latched code or polarity changes a pair's waveform within one reference period of the boundary where it is taken. A stop flag that freezes or releases at the wrong tick gives a shortened pulse or a level held past a natural edge, and this shows in the tick where it happens. An error in the special-mode decode changes the period of pair 3 or 4 and shows within four reference periods.

// File: rtl/skew_clk_bank.sv
module skew_clk_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_in,
  input  logic [1:0]  range_sel,
  input  logic [1:0]  test_sel,
  input  logic        pol_rise,
  input  logic        soe_stop,
  input  logic        pwr_on,
  input  logic [15:0] pair_code,
  output logic [7:0]  clk_out
);

  function automatic logic [1:0] lvl3(input logic [1:0] v);
    return (v == 2'b11) ? 2'b01 : v;
  endfunction

  function automatic logic [3:0] code_idx(input logic [3:0] f);
    return {2'b0, lvl3(f[3:2])} * 4'd3 + {2'b0, lvl3(f[1:0])};
  endfunction

  function automatic logic wave(input int g, input logic [3:0] c, input logic [6:0] tk,
                                input logic [6:0] pm, input logic pl);
    logic [6:0] wrap, half, skw, t;
    logic sp;
    wrap = {pm[4:0], 2'b11};
    half = {1'b0, pm[6:1]} + 7'd1;
    sp   = (g >= 2) && (c == 4'd0 || c == 4'd8);
    skw  = {3'b0, c} - 7'd4;
    if (g >= 2) skw = skw << 1;
    if (sp) skw = 7'd0;
    t = (tk - skw - (pl ? 7'd0 : half)) & wrap;
    if (g >= 2 && c == 4'd0) return (t & {pm[5:0], 1'b1}) <= pm;
    if (g == 2 && c == 4'd8) return t <= {pm[5:0], 1'b1};
    return ((t & pm) < half) ^ (g == 3 && c == 4'd8);
  endfunction

  logic [6:0]      tick;
  logic [1:0]      rng_q;
  logic            pol_q;
  logic [3:0][3:0] code_q;
  logic [6:0]      pmask;
  logic [3:0]      run, lvl, req, stp, prv, oq;
  logic [1:0]      tmode;
  logic            bypass, frame_end, period_end;

  always_comb begin
    case (rng_q)
      2'b00:   pmask = 7'd31;
      2'b10:   pmask = 7'd7;
      default: pmask = 7'd15;
    endcase
  end

  assign frame_end  = tick == {pmask[4:0], 2'b11};
  assign period_end = (tick & pmask) == pmask;
  assign tmode      = lvl3(test_sel);
  assign bypass     = (tmode == 2'b10) || (tmode == 2'b01 && !soe_stop);

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      run[i] = wave(i, code_q[i], tick, pmask, pol_q);
      lvl[i] = (i == 3 && code_q[3] == 4'd8) ? pol_q : 1'b0;
      req[i] = (tmode == 2'b01) ? (code_q[i] == 4'd0) : (soe_stop && i != 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick   <= '0;
      rng_q  <= 2'b01;
      pol_q  <= 1'b1;
      code_q <= {4{4'd4}};
      stp    <= '0;
      prv    <= '0;
      oq     <= '0;
    end else begin
      tick <= frame_end ? 7'd0 : tick + 7'd1;
      if (frame_end) rng_q <= lvl3(range_sel);
      if (period_end) begin
        pol_q <= pol_rise;
        for (int i = 0; i < 4; i++) code_q[i] <= code_idx(pair_code[4*i +: 4]);
      end
      prv <= run;
      if (!pwr_on) begin
        oq  <= '0;
        stp <= '0;
      end else if (bypass) begin
        oq  <= {4{ref_in}};
        stp <= '0;
      end else begin
        for (int i = 0; i < 4; i++) begin
          if (stp[i]) begin
            if (!req[i] && run[i] != lvl[i] && prv[i] == lvl[i]) begin
              stp[i] <= 1'b0;
              oq[i]  <= run[i];
            end else begin
              oq[i]  <= lvl[i];
            end
          end else begin
            oq[i] <= run[i];
            if (req[i] && run[i] == lvl[i]) stp[i] <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_pin
    assign clk_out[2*g +: 2] = {2{oq[g]}};
  end

  // R12
  pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> clk_out == 8'h00);

  // R11
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && pwr_on) |=> clk_out == {8{$past(ref_in)}});

  // R7
  code_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> (tick & pmask) == 7'd0);

  // R2
  range_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rng_q) |-> tick == 7'd0);

endmodule

// File: tb/skew_clk_bank_tb.sv
module skew_clk_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic [1:0]  range_sel = 2'b01;
  logic [1:0]  test_sel = 2'b00;
  logic        pol_rise = 1'b1;
  logic        soe_stop = 1'b0;
  logic        pwr_on = 1'b1;
  logic [15:0] pair_code = 16'h5555;
  logic [7:0]  clk_out;

  skew_clk_bank dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .range_sel(range_sel),
    .test_sel(test_sel), .pol_rise(pol_rise), .soe_stop(soe_stop),
    .pwr_on(pwr_on), .pair_code(pair_code), .clk_out(clk_out)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0, miscompares = 0, cycles = 0;
  string tag = "R1 reset";
  logic [7:0] expv = 8'h00;

  int mT, mRng, mPol;
  int mCode[4], mPrev[4], mStp[4], mOut[4];

  function automatic int dig(input logic [1:0] v);
    return (v == 2'b00) ? 0 : (v == 2'b10) ? 2 : 1;
  endfunction

  function automatic int pmod(input int x, input int m);
    return ((x % m) + m) % m;
  endfunction

  function automatic int ref_wave(input int i, input int c, input int T, input int P, input int pol);
    int sk, t;
    bit special;
    special = (i >= 2) && (c == 0 || c == 8);
    sk = (i < 2) ? c - 4 : 2 * (c - 4);
    if (special) sk = 0;
    t = pmod(T - sk - (pol ? 0 : P / 2), 4 * P);
    if (i >= 2 && c == 0) return ((t % (2 * P)) < P) ? 1 : 0;
    if (i == 2 && c == 8) return (t < 2 * P) ? 1 : 0;
    if (i == 3 && c == 8) return ((t % P) < P / 2) ? 0 : 1;
    return ((t % P) < P / 2) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int P, tl, run[4], lv[4];
    bit rq;
    if (!rst_n) begin
      mT = 0; mRng = 1; mPol = 1;
      for (int i = 0; i < 4; i++) begin
        mCode[i] = 4; mPrev[i] = 0; mStp[i] = 0; mOut[i] = 0;
      end
    end else begin
      P = (mRng == 0) ? 32 : (mRng == 1) ? 16 : 8;
      tl = dig(test_sel);
      for (int i = 0; i < 4; i++) begin
        run[i] = ref_wave(i, mCode[i], mT, P, mPol);
        lv[i]  = (i == 3 && mCode[3] == 8) ? mPol : 0;
      end
      if (!pwr_on) begin
        for (int i = 0; i < 4; i++) begin mOut[i] = 0; mStp[i] = 0; end
      end else if (tl == 2 || (tl == 1 && !soe_stop)) begin
        for (int i = 0; i < 4; i++) begin mOut[i] = ref_in; mStp[i] = 0; end
      end else begin
        for (int i = 0; i < 4; i++) begin
          rq = (tl == 1) ? (mCode[i] == 0) : (soe_stop && i != 1);
          if (mStp[i] != 0) begin
            if (!rq && run[i] != lv[i] && mPrev[i] == lv[i]) begin
              mStp[i] = 0; mOut[i] = run[i];
            end else mOut[i] = lv[i];
          end else begin
            mOut[i] = run[i];
            if (rq && run[i] == lv[i]) mStp[i] = 1;
          end
        end
      end
      for (int i = 0; i < 4; i++) mPrev[i] = run[i];
      if (mT % P == P - 1) begin
        mPol = pol_rise;
        for (int i = 0; i < 4; i++)
          mCode[i] = 3 * dig(pair_code[4*i+2 +: 2]) + dig(pair_code[4*i +: 2]);
      end
      if (mT == 4 * P - 1) begin
        mRng = dig(range_sel); mT = 0;
      end else mT = mT + 1;
    end
    for (int i = 0; i < 4; i++) begin
      expv[2*i]   = mOut[i][0];
      expv[2*i+1] = mOut[i][0];
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (clk_out !== expv) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: clk_out=%b expected %b", tag, cycles, clk_out, expv);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, cycles=%0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [1:0] enc(input int d);
    return (d == 0) ? 2'b00 : (d == 2) ? 2'b10 : 2'b01;
  endfunction

  task automatic setc(input int p, input int c);
    pair_code[4*p +: 4] = {enc(c / 3), enc(c % 3)};
  endtask

  initial begin
    ticks(5);
    rst_n = 1'b1;
    tag = "R1 defaults zero skew";
    ticks(100);
    tag = "R1 code 11 reads MID";
    pair_code = 16'hFFFF; range_sel = 2'b11;
    ticks(140);
    pair_code = 16'h5555; range_sel = 2'b01;
    tag = "R3 pairs 1-2 skew table";
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 9; c++) begin setc(p, c); ticks(40); end
      setc(p, 4);
    end
    tag = "R4 R5 pairs 3-4 table and special codes";
    for (int p = 2; p < 4; p++) begin
      for (int c = 0; c < 9; c++) begin setc(p, c); ticks(140); end
      setc(p, 4);
    end
    tag = "R2 range LOW";
    setc(0, 2); setc(2, 0); setc(3, 7);
    range_sel = 2'b00; ticks(300);
    tag = "R2 range HIGH";
    range_sel = 2'b10; ticks(200);
    range_sel = 2'b01; ticks(100);
    tag = "R6 falling-edge polarity";
    pol_rise = 1'b0; setc(2, 8); ticks(150);
    pol_rise = 1'b1; ticks(40);
    tag = "R7 mid-period code change";
    ticks(3); setc(0, 6); ticks(5); setc(1, 1); ticks(11); setc(3, 2); ticks(7); setc(0, 0); ticks(40);
    tag = "R8 R9 stop with pair 2 exempt";
    setc(3, 8); setc(1, 7);
    ticks(20); soe_stop = 1'b1; ticks(100); soe_stop = 1'b0; ticks(70);
    tag = "R9 inverted pair stop level, falling polarity";
    pol_rise = 1'b0; ticks(20); soe_stop = 1'b1; ticks(90); soe_stop = 1'b0; ticks(60);
    tag = "R8 short stop pulses";
    for (int k = 0; k < 12; k++) begin soe_stop = ~soe_stop; ticks(3 + k); end
    soe_stop = 1'b0; pol_rise = 1'b1; ticks(60);
    tag = "R10 test MID disables LL pairs";
    setc(0, 0); setc(2, 0); setc(1, 3); setc(3, 5);
    ticks(20); test_sel = 2'b01; soe_stop = 1'b1; ticks(150);
    tag = "R11 bypass test MID stop LOW";
    soe_stop = 1'b0;
    for (int k = 0; k < 30; k++) begin ref_in = ~ref_in; ticks(2); end
    tag = "R11 bypass test HIGH";
    test_sel = 2'b10; soe_stop = 1'b1;
    for (int k = 0; k < 30; k++) begin ref_in = ~ref_in; ticks(1 + k % 3); end
    test_sel = 2'b00; soe_stop = 1'b0; ticks(80);
    tag = "R12 power-down";
    pwr_on = 1'b0; ticks(30); pwr_on = 1'b1; ticks(100);
    tag = "R1 reset mid-run";
    rst_n = 1'b0; ticks(3); rst_n = 1'b1; ticks(40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule